// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small programmable logic device. It forms 26 input signals: 14 dedicated inputs and 12 feedback lines that return from the output stage. Every product term can use either polarity of each signal. Each product term is the AND of the literals its connection mask selects. The product terms are divided into twelve fixed OR groups, one for each output. The groups are of unequal size, so the outputs in the middle of the array have more terms available than the outputs at its edges.

The connection masks are held in a static configuration store. A write port loads one term's mask per clock, and an erase command returns the whole array to its blank state. The AND and OR planes are purely combinational. The outputs therefore follow every input change at once, and they follow every mask change starting from the clock edge that stored it.

Top module: `spa_array`

## Requirements
- R1: After reset every mask is clear, and every output reads 1 for any input values.
- R2: Signal k is `ded_in[k]` for k from 0 to 13 and `fb_in[k-14]` for k from 14 to 25. Mask bit 2k selects signal k and mask bit 2k+1 selects its complement.
- R3: A product term is the AND of the literals its mask selects. A term with an all-zero mask (unprogrammed) evaluates to 1.
- R4: A term whose mask sets both bit 2k and bit 2k+1 for any k evaluates to 0 for every input value.
- R5: Output o is the OR of its own group of terms. The group sizes for outputs 0 to 11 are 8, 10, 12, 14, 16, 16, 16, 16, 14, 12, 10, 8. Term indices run contiguously from output 0 upward, so output 3 owns terms 30 to 43, output 4 starts at term 44, and output 11 ends at term 151.
- R6: A write with `cfg_we` high stores `cfg_mask` for term `cfg_idx` at the rising clock edge. The outputs change only from that edge on.
- R7: A write to an index of 152 or above changes no mask. In the following cycle `cfg_err` is high for one cycle. After a write to an index in range, `cfg_err` stays low.
- R8: `cfg_erase` clears every mask at the next clock edge. A write in the same cycle as an erase is discarded.
- R9: The outputs respond to changes on `ded_in` and `fb_in` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all masks |
| cfg_we | input | 1 | Write strobe for one term mask |
| cfg_erase | input | 1 | Clears every mask; has priority over a write |
| cfg_idx | input | 8 | Term index of the write |
| cfg_mask | input | 52 | Connection mask to store |
| cfg_err | output | 1 | One-cycle pulse after an out-of-range write |
| ded_in | input | 14 | Dedicated inputs |
| fb_in | input | 12 | Feedback inputs |
| sum_out | output | 12 | OR-group results, one bit per output |

## Verification
On every clock cycle, the assertions check the following: a term with a conflicting literal pair is low, the masks stay stable without a write or an erase, an erase leaves all outputs high, and the error flag follows exactly the out-of-range writes. Some behaviours can only be shown by the bench's scenarios. These are the polarity encoding of each literal, the exact split of term indices between OR groups at their boundaries, the discarding of a write that meets an erase, and the response of the outputs to input changes between clock edges.

// File: rtl/spa_pkg.sv
package spa_pkg;

   // Number of product terms in OR group o: grows by two from each edge
   // of the array toward the middle, capped at max_pt.
   function automatic int pt_count(int o, int n_out, int min_pt, int max_pt);
      int edge_dist;
      int c;
      edge_dist = (o < (n_out - 1 - o)) ? o : (n_out - 1 - o);
      c = min_pt + 2 * edge_dist;
      return (c > max_pt) ? max_pt : c;
   endfunction

   // First term index of OR group o (pt_base(n_out,...) gives the total).
   function automatic int pt_base(int o, int n_out, int min_pt, int max_pt);
      int acc;
      acc = 0;
      for (int i = 0; i < o; i++) acc += pt_count(i, n_out, min_pt, max_pt);
      return acc;
   endfunction

endpackage

// File: rtl/spa_cfg_store.sv
module spa_cfg_store #(
   parameter int N_TERMS = 152,
   parameter int MASK_W  = 52,
   parameter int IDX_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic                       erase,
   input  logic [IDX_W-1:0]           idx,
   input  logic [MASK_W-1:0]          mask,
   output logic [N_TERMS*MASK_W-1:0]  masks_flat,
   output logic                       err
);
   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(N_TERMS);

   logic in_range;
   assign in_range = ({1'b0, idx} < LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         masks_flat <= '0;
         err        <= 1'b0;
      end else begin
         err <= we && !in_range;
         if (erase) begin
            masks_flat <= '0;
         end else if (we && in_range) begin
            masks_flat[idx*MASK_W +: MASK_W] <= mask;
         end
      end
   end

   // R6: masks only move on a write or an erase
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && !erase) |=> $stable(masks_flat));

endmodule

// File: rtl/spa_and_plane.sv
module spa_and_plane #(
   parameter int N_SIG   = 26,
   parameter int N_TERMS = 152
) (
   input  logic [N_SIG-1:0]            sig,
   input  logic [N_TERMS*2*N_SIG-1:0]  masks_flat,
   output logic [N_TERMS-1:0]          terms
);
   localparam int MASK_W = 2 * N_SIG;

   logic [MASK_W-1:0] lit;

   for (genvar k = 0; k < N_SIG; k++) begin : g_lit
      assign lit[2*k]   = sig[k];
      assign lit[2*k+1] = ~sig[k];
   end

   // A literal that is not selected reads as 1, so an empty mask gives 1
   // and a true/complement pair gives 0.
   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      logic [MASK_W-1:0] m;
      assign m        = masks_flat[t*MASK_W +: MASK_W];
      assign terms[t] = &(lit | ~m);
   end

endmodule

// File: rtl/spa_or_plane.sv
module spa_or_plane #(
   parameter int N_OUT   = 12,
   parameter int MIN_PT  = 8,
   parameter int MAX_PT  = 16,
   parameter int N_TERMS = 152
) (
   input  logic [N_TERMS-1:0] terms,
   output logic [N_OUT-1:0]   sums
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_grp
      localparam int BASE = spa_pkg::pt_base(o, N_OUT, MIN_PT, MAX_PT);
      localparam int CNT  = spa_pkg::pt_count(o, N_OUT, MIN_PT, MAX_PT);
      if (BASE + CNT > N_TERMS) begin : g_bad
         $error("OR group %0d exceeds the term count", o);
      end
      assign sums[o] = |terms[BASE +: CNT];
   end

endmodule

// File: rtl/spa_array.sv
module spa_array #(
   parameter int N_DED  = 14,
   parameter int N_OUT  = 12,
   parameter int MIN_PT = 8,
   parameter int MAX_PT = 16,
   parameter int IDX_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic                        cfg_erase,
   input  logic [IDX_W-1:0]            cfg_idx,
   input  logic [2*(N_DED+N_OUT)-1:0]  cfg_mask,
   output logic                        cfg_err,
   input  logic [N_DED-1:0]            ded_in,
   input  logic [N_OUT-1:0]            fb_in,
   output logic [N_OUT-1:0]            sum_out
);
   localparam int N_SIG   = N_DED + N_OUT;
   localparam int MASK_W  = 2 * N_SIG;
   localparam int N_TERMS = spa_pkg::pt_base(N_OUT, N_OUT, MIN_PT, MAX_PT);
   localparam logic [MASK_W-1:0] EVEN_SEL = {N_SIG{2'b01}};

   if (MIN_PT < 1 || MAX_PT < MIN_PT) begin : g_bad_pt
      $error("product-term bounds are inconsistent");
   end
   if (N_TERMS > (1 << IDX_W)) begin : g_bad_idx
      $error("index width too small for %0d terms", N_TERMS);
   end

   logic [N_TERMS*MASK_W-1:0] masks_flat;
   logic [N_TERMS-1:0]        terms;
   logic [N_SIG-1:0]          sig;

   assign sig = {fb_in, ded_in};

   spa_cfg_store #(.N_TERMS(N_TERMS), .MASK_W(MASK_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .erase(cfg_erase),
      .idx(cfg_idx), .mask(cfg_mask), .masks_flat(masks_flat), .err(cfg_err)
   );

   spa_and_plane #(.N_SIG(N_SIG), .N_TERMS(N_TERMS)) u_and (
      .sig(sig), .masks_flat(masks_flat), .terms(terms)
   );

   spa_or_plane #(.N_OUT(N_OUT), .MIN_PT(MIN_PT), .MAX_PT(MAX_PT),
                  .N_TERMS(N_TERMS)) u_or (
      .terms(terms), .sums(sum_out)
   );

   // R4: any conflicting literal pair forces its term low
   for (genvar t = 0; t < N_TERMS; t++) begin : g_chk
      logic [MASK_W-1:0] m;
      assign m = masks_flat[t*MASK_W +: MASK_W];
      p_conflict_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (|(m & (m >> 1) & EVEN_SEL)) |-> !terms[t]);
   end

   // R8: after an erase every group holds only empty terms
   p_erase_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_erase |=> (sum_out == '1));

   // R7: flag follows an out-of-range write
   p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && ({1'b0, cfg_idx} >= (IDX_W+1)'(N_TERMS))) |=> cfg_err);

   p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_we));

endmodule

// File: tb/spa_array_bench.sv
module spa_array_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_erase = 1'b0;
   logic [7:0]  cfg_idx = '0;
   logic [51:0] cfg_mask = '0;
   logic        cfg_err;
   logic [13:0] ded_in = '0;
   logic [11:0] fb_in = '0;
   logic [11:0] sum_out;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   spa_array u_spa_array (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_erase(cfg_erase),
      .cfg_idx(cfg_idx), .cfg_mask(cfg_mask), .cfg_err(cfg_err),
      .ded_in(ded_in), .fb_in(fb_in), .sum_out(sum_out)
   );

   // {ded, fb, expected} under the programming applied below:
   // out0=d0, out1=~d1, out2=d2&d3, out3=fb0|d4, out11=~fb11, rest 0
   localparam logic [37:0] VECS [6] = '{
      {14'h0000, 12'h000, 12'h802},
      {14'h0001, 12'h800, 12'h003},
      {14'h000E, 12'h000, 12'h804},
      {14'h0010, 12'h800, 12'h00A},
      {14'h3FFF, 12'hFFF, 12'h00D},
      {14'h0000, 12'h001, 12'h80A}
   };

   task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_term(int idx, logic [51:0] m);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 8'(idx); cfg_mask = m;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 reset all high", sum_out, 12'hFFF);
      chk("R1 reset err low", {11'd0, cfg_err}, 12'h000);

      // R4: every term gets the pair d0 and ~d0
      for (int i = 0; i < 152; i++) write_term(i, 52'h3);
      #1;
      chk("R4 conflicting terms low", sum_out, 12'h000);
      chk("R7 in-range write no err", {11'd0, cfg_err}, 12'h000);

      write_term(0,   52'd1 << 0);
      write_term(8,   52'd1 << 3);
      write_term(18, (52'd1 << 4) | (52'd1 << 6));
      write_term(30,  52'd1 << 28);
      write_term(43,  52'd1 << 8);
      write_term(151, 52'd1 << 51);

      // R2 R3 R5: vector table
      for (int v = 0; v < 6; v++) begin
         ded_in = VECS[v][37:24];
         fb_in  = VECS[v][23:12];
         #1;
         chk($sformatf("R2 R3 R5 vector %0d", v), sum_out, VECS[v][11:0]);
      end

      // R9: input change between edges
      @(posedge clk); #1;
      ded_in = 14'h0001; fb_in = 12'h000;
      #1;
      chk("R9 async rise", sum_out, 12'h803);
      ded_in = 14'h0000;
      #1;
      chk("R9 async fall", sum_out, 12'h802);

      // R5: first term of output 4 belongs to output 4 only
      write_term(44, 52'h0);
      #1;
      chk("R5 group boundary 44", sum_out, 12'h812);
      write_term(44, 52'h3);
      #1;
      chk("R5 boundary restored", sum_out, 12'h802);

      // R6: write lands at the rising edge
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 8'd1; cfg_mask = 52'h0;
      #1;
      chk("R6 before edge", sum_out, 12'h802);
      @(posedge clk); #1;
      chk("R6 after edge", sum_out, 12'h803);
      @(negedge clk);
      cfg_we = 1'b0;
      write_term(1, 52'h3);

      // R7: out-of-range writes
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 8'd152; cfg_mask = 52'h0;
      @(posedge clk); #1;
      chk("R7 err pulse 152", {11'd0, cfg_err}, 12'h001);
      chk("R7 idx 152 ignored", sum_out, 12'h802);
      cfg_idx = 8'd255;
      @(posedge clk); #1;
      chk("R7 idx 255 ignored", sum_out, 12'h802);
      @(negedge clk);
      cfg_we = 1'b0;
      @(posedge clk); #1;
      chk("R7 err pulse ends", {11'd0, cfg_err}, 12'h000);

      // R8: erase with a same-cycle write
      @(negedge clk);
      cfg_erase = 1'b1; cfg_we = 1'b1; cfg_idx = 8'd0; cfg_mask = 52'h3;
      @(negedge clk);
      cfg_erase = 1'b0; cfg_we = 1'b0;
      #1;
      chk("R8 erase all high", sum_out, 12'hFFF);
      for (int i = 1; i < 8; i++) write_term(i, 52'h3);
      ded_in = 14'h0000;
      #1;
      chk("R8 erase wins over write", {11'd0, sum_out[0]}, 12'h001);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule